// File: doc/BRIEF.md
# Paged MMIO Region Dispatcher

This block sits between a CPU's memory access path and a set of memory-mapped devices. It splits a 32-bit physical address space into 16 KiB pages. Each page in a table has a kind (ordinary RAM, device, or sink), a device index, a width attribute and the first page of the region it belongs to. A registration port claims a run of pages for one device. An access port takes byte or word reads and writes, looks up the page and forwards the access to the device port with an offset measured from the region's base.

Some regions accept only bytes. A word access to such a region becomes four byte accesses on consecutive cycles, and a read is assembled least significant byte first. Pages from the RAM size upward fall through to a built-in sink, which returns all-ones and discards writes. The table covers the low `TBL_PAGES` pages, and every page above that is always a sink. A RAM page that no device claims completes at once with a miss flag, so that the caller can route the access to RAM.

Top module: `mmio_dispatch`

## Requirements
- R1: The page index is address bits [31:14]. Pages at or above `RAM_PAGES` that no device has claimed, and every page at or above `TBL_PAGES`, act as a sink. A word read returns 0xFFFFFFFF, a byte read returns 0x000000FF and a write is dropped. No device request is made, and `acc_done_o` rises in the cycle after acceptance.
- R2: A registration is rejected in any of these cases: the base has bits [13:0] nonzero, the size has bits [13:0] nonzero, the size is zero, or base page plus page count exceeds `TBL_PAGES`. On rejection, `reg_err_o` pulses in the cycle after acceptance, `reg_busy_o` stays low and the table is left as it was.
- R3: A valid registration of N pages holds `reg_busy_o` high for exactly N cycles, starting the cycle after acceptance. `acc_ready_o` is low for the whole time and no device request is made.
- R4: A later registration replaces the entries of any pages it shares with an earlier one. Pages outside the overlap keep their old binding.
- R5: `dev_sel_o` carries the registered device index, and `dev_off_o` carries the access address minus the region base address.
- R6: A word access to a region registered 4-wide (`reg_wide_i`=1) makes one request with `dev_wide_o`=1. The request carries all 32 data bits in both directions, and done follows in the next cycle.
- R7: A word read of a byte-wide region makes four requests on consecutive cycles at offsets +0, +1, +2 and +3. Byte k comes from `dev_rdata_i[7:0]` and lands in result bits [8k+7:8k]. Done follows the last request by one cycle.
- R8: A word write to a byte-wide region makes four requests with `dev_we_o`=1. Beat k carries write-data bits [8k+7:8k] on `dev_wdata_o[7:0]`.
- R9: A byte access (`acc_word_i`=0) makes one request with `dev_wide_o`=0, and the read result is `dev_rdata_i[7:0]` zero-extended.
- R10: An unclaimed page below `RAM_PAGES` completes in the cycle after acceptance with `acc_miss_o`=1 and a read result of 0. No device request is made.
- R11: After reset, `reg_busy_o`, `reg_err_o`, `acc_done_o` and `dev_req_o` are low, and `acc_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_valid_i | input | 1 | Registration request |
| reg_base_i | input | ADDR_W | Region base address |
| reg_size_i | input | ADDR_W | Region size in bytes |
| reg_dev_i | input | log2(NDEV) | Device index to bind |
| reg_wide_i | input | 1 | 1: region takes 4-byte accesses, 0: bytes only |
| reg_busy_o | output | 1 | Page walk in progress |
| reg_err_o | output | 1 | Registration rejected (one-cycle pulse) |
| acc_valid_i | input | 1 | Access request |
| acc_ready_o | output | 1 | Access can be accepted |
| acc_we_i | input | 1 | 1: write, 0: read |
| acc_word_i | input | 1 | 1: 32-bit access, 0: byte access |
| acc_addr_i | input | ADDR_W | Physical address |
| acc_wdata_i | input | 32 | Write data (byte access uses bits [7:0]) |
| acc_done_o | output | 1 | Access complete (one-cycle pulse) |
| acc_miss_o | output | 1 | With done: unclaimed RAM page |
| acc_rdata_o | output | 32 | Read result, valid with done |
| dev_req_o | output | 1 | Device access strobe |
| dev_sel_o | output | log2(NDEV) | Selected device index |
| dev_we_o | output | 1 | Device write |
| dev_wide_o | output | 1 | 1: 32-bit device access, 0: byte |
| dev_off_o | output | ADDR_W | Offset from region base |
| dev_wdata_o | output | 32 | Device write data |
| dev_rdata_i | input | 32 | Device read data, same cycle as request |

## Verification
Some properties are checked by assertions on every cycle. Split beats step the offset by one and keep the device select steady. A wide request is never followed by another request. Done is a single-cycle pulse. A rejected registration never raises busy. While the walker runs, no access is accepted and no request goes to a device. The bench scenarios cover the rest: the sink's all-ones data, little-endian assembly of split reads, byte order on split writes, offsets taken from the region base, overwriting by a later registration, the miss flag, and the exact busy length for each page count.

// File: rtl/mmio_disp_pkg.sv
package mmio_disp_pkg;
  typedef enum logic [1:0] {PG_RAM = 2'd0, PG_DEV = 2'd1, PG_SINK = 2'd2} pg_kind_e;
  typedef enum logic [1:0] {X_IDLE = 2'd0, X_ISSUE = 2'd1, X_RESP = 2'd2} xfer_st_e;
endpackage

// File: rtl/mmio_page_table.sv
module mmio_page_table
  import mmio_disp_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 14,
  parameter int TBL_PAGES = 64,
  parameter int RAM_PAGES = 32,
  parameter int NDEV      = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          reg_go_i,
  input  logic [ADDR_W-1:0]             reg_base_i,
  input  logic [ADDR_W-1:0]             reg_size_i,
  input  logic [$clog2(NDEV)-1:0]       reg_dev_i,
  input  logic                          reg_wide_i,
  output logic                          busy_o,
  output logic                          err_o,
  input  logic [ADDR_W-PAGE_BITS-1:0]   lk_page_i,
  output pg_kind_e                      lk_kind_o,
  output logic [$clog2(NDEV)-1:0]       lk_dev_o,
  output logic                          lk_wide_o,
  output logic [ADDR_W-PAGE_BITS-1:0]   lk_base_o
);
  localparam int PG_W   = ADDR_W - PAGE_BITS;
  localparam int TIDX_W = $clog2(TBL_PAGES);
  localparam int DEV_W  = $clog2(NDEV);

  pg_kind_e          kind_q [TBL_PAGES];
  logic [DEV_W-1:0]  dev_q  [TBL_PAGES];
  logic              wide_q [TBL_PAGES];
  logic [PG_W-1:0]   base_q [TBL_PAGES];

  logic              busy_q, err_q, wwide_q;
  logic [TIDX_W-1:0] cur_q;
  logic [PG_W-1:0]   left_q, wbase_q;
  logic [DEV_W-1:0]  wdev_q;

  logic [PG_W-1:0] req_pg, req_n;
  logic [PG_W:0]   req_end;
  logic            bad;

  assign req_pg  = reg_base_i[ADDR_W-1:PAGE_BITS];
  assign req_n   = reg_size_i[ADDR_W-1:PAGE_BITS];
  assign req_end = {1'b0, req_pg} + {1'b0, req_n};
  assign bad     = (|reg_base_i[PAGE_BITS-1:0]) || (|reg_size_i[PAGE_BITS-1:0]) ||
                   (req_n == '0) || (req_end > (PG_W+1)'(TBL_PAGES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
      cur_q   <= '0;
      left_q  <= '0;
      wbase_q <= '0;
      wdev_q  <= '0;
      wwide_q <= 1'b0;
      for (int i = 0; i < TBL_PAGES; i++) begin
        kind_q[i] <= (i < RAM_PAGES) ? PG_RAM : PG_SINK;
        dev_q[i]  <= '0;
        wide_q[i] <= 1'b0;
        base_q[i] <= PG_W'(RAM_PAGES);
      end
    end else begin
      err_q <= reg_go_i && bad;
      if (reg_go_i && !bad) begin
        busy_q  <= 1'b1;
        cur_q   <= req_pg[TIDX_W-1:0];
        left_q  <= req_n;
        wbase_q <= req_pg;
        wdev_q  <= reg_dev_i;
        wwide_q <= reg_wide_i;
      end else if (busy_q) begin
        kind_q[cur_q] <= PG_DEV;
        dev_q[cur_q]  <= wdev_q;
        wide_q[cur_q] <= wwide_q;
        base_q[cur_q] <= wbase_q;
        cur_q  <= cur_q + 1'b1;
        left_q <= left_q - 1'b1;
        if (left_q == PG_W'(1)) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign err_o  = err_q;

  logic in_tbl;
  assign in_tbl = lk_page_i < PG_W'(TBL_PAGES);

  always_comb begin
    if (in_tbl) begin
      lk_kind_o = kind_q[lk_page_i[TIDX_W-1:0]];
      lk_dev_o  = dev_q[lk_page_i[TIDX_W-1:0]];
      lk_wide_o = wide_q[lk_page_i[TIDX_W-1:0]];
      lk_base_o = base_q[lk_page_i[TIDX_W-1:0]];
    end else begin
      lk_kind_o = PG_SINK;
      lk_dev_o  = '0;
      lk_wide_o = 1'b0;
      lk_base_o = PG_W'(RAM_PAGES);
    end
  end

  AST_ERR_NO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o); // R2
  AST_WALK_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !err_o); // R3
endmodule

// File: rtl/mmio_xfer.sv
module mmio_xfer
  import mmio_disp_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 14,
  parameter int NDEV      = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        go_i,
  input  logic                        we_i,
  input  logic                        word_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [31:0]                 wdata_i,
  input  pg_kind_e                    kind_i,
  input  logic [$clog2(NDEV)-1:0]     dev_i,
  input  logic                        wide_i,
  input  logic [ADDR_W-PAGE_BITS-1:0] base_i,
  output logic                        idle_o,
  output logic                        done_o,
  output logic                        miss_o,
  output logic [31:0]                 rdata_o,
  output logic                        dev_req_o,
  output logic [$clog2(NDEV)-1:0]     dev_sel_o,
  output logic                        dev_we_o,
  output logic                        dev_wide_o,
  output logic [ADDR_W-1:0]           dev_off_o,
  output logic [31:0]                 dev_wdata_o,
  input  logic [31:0]                 dev_rdata_i
);
  localparam int DEV_W = $clog2(NDEV);

  xfer_st_e         st_q;
  logic             we_q, fwd_wide_q, miss_q;
  logic [1:0]       beat_q, last_q;
  logic [ADDR_W-1:0] off_q;
  logic [31:0]      wdata_q, rdata_q;
  logic [DEV_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= X_IDLE;
      we_q       <= 1'b0;
      fwd_wide_q <= 1'b0;
      miss_q     <= 1'b0;
      beat_q     <= '0;
      last_q     <= '0;
      off_q      <= '0;
      wdata_q    <= '0;
      rdata_q    <= '0;
      sel_q      <= '0;
    end else begin
      case (st_q)
        X_IDLE: if (go_i) begin
          we_q       <= we_i;
          wdata_q    <= wdata_i;
          sel_q      <= dev_i;
          off_q      <= addr_i - {base_i, {PAGE_BITS{1'b0}}};
          beat_q     <= '0;
          fwd_wide_q <= word_i && wide_i;
          last_q     <= (word_i && !wide_i) ? 2'd3 : 2'd0;
          miss_q     <= (kind_i == PG_RAM);
          case (kind_i)
            PG_DEV:  begin rdata_q <= '0; st_q <= X_ISSUE; end
            PG_SINK: begin rdata_q <= word_i ? 32'hFFFF_FFFF : 32'h0000_00FF; st_q <= X_RESP; end
            default: begin rdata_q <= '0; st_q <= X_RESP; end
          endcase
        end
        X_ISSUE: begin
          if (fwd_wide_q) rdata_q <= dev_rdata_i;
          else            rdata_q[8*beat_q +: 8] <= dev_rdata_i[7:0];
          beat_q <= beat_q + 1'b1;
          if (beat_q == last_q) st_q <= X_RESP;
        end
        default: st_q <= X_IDLE;
      endcase
    end
  end

  assign idle_o      = (st_q == X_IDLE);
  assign done_o      = (st_q == X_RESP);
  assign miss_o      = done_o && miss_q;
  assign rdata_o     = rdata_q;
  assign dev_req_o   = (st_q == X_ISSUE);
  assign dev_sel_o   = sel_q;
  assign dev_we_o    = we_q;
  assign dev_wide_o  = fwd_wide_q;
  assign dev_off_o   = off_q + ADDR_W'(beat_q);
  assign dev_wdata_o = fwd_wide_q ? wdata_q : {24'h0, wdata_q[8*beat_q +: 8]};

  AST_SPLIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_req_o && $past(dev_req_o) |-> dev_off_o == $past(dev_off_o) + 1); // R7
  AST_SPLIT_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_req_o && $past(dev_req_o) |-> $stable(dev_sel_o)); // R5
  AST_WIDE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_req_o && dev_wide_o |=> !dev_req_o && done_o); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
endmodule

// File: rtl/mmio_dispatch.sv
module mmio_dispatch
  import mmio_disp_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 14,
  parameter int TBL_PAGES = 64,
  parameter int RAM_PAGES = 32,
  parameter int NDEV      = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    reg_valid_i,
  input  logic [ADDR_W-1:0]       reg_base_i,
  input  logic [ADDR_W-1:0]       reg_size_i,
  input  logic [$clog2(NDEV)-1:0] reg_dev_i,
  input  logic                    reg_wide_i,
  output logic                    reg_busy_o,
  output logic                    reg_err_o,
  input  logic                    acc_valid_i,
  output logic                    acc_ready_o,
  input  logic                    acc_we_i,
  input  logic                    acc_word_i,
  input  logic [ADDR_W-1:0]       acc_addr_i,
  input  logic [31:0]             acc_wdata_i,
  output logic                    acc_done_o,
  output logic                    acc_miss_o,
  output logic [31:0]             acc_rdata_o,
  output logic                    dev_req_o,
  output logic [$clog2(NDEV)-1:0] dev_sel_o,
  output logic                    dev_we_o,
  output logic                    dev_wide_o,
  output logic [ADDR_W-1:0]       dev_off_o,
  output logic [31:0]             dev_wdata_o,
  input  logic [31:0]             dev_rdata_i
);
  localparam int PG_W  = ADDR_W - PAGE_BITS;
  localparam int DEV_W = $clog2(NDEV);

  logic             xfer_idle, reg_go, acc_go;
  pg_kind_e         lk_kind;
  logic [DEV_W-1:0] lk_dev;
  logic             lk_wide;
  logic [PG_W-1:0]  lk_base;

  assign reg_go      = reg_valid_i && !reg_busy_o && xfer_idle;
  assign acc_ready_o = xfer_idle && !reg_busy_o && !reg_valid_i;
  assign acc_go      = acc_valid_i && acc_ready_o;

  mmio_page_table #(
    .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .TBL_PAGES(TBL_PAGES),
    .RAM_PAGES(RAM_PAGES), .NDEV(NDEV)
  ) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_go_i   (reg_go),
    .reg_base_i (reg_base_i),
    .reg_size_i (reg_size_i),
    .reg_dev_i  (reg_dev_i),
    .reg_wide_i (reg_wide_i),
    .busy_o     (reg_busy_o),
    .err_o      (reg_err_o),
    .lk_page_i  (acc_addr_i[ADDR_W-1:PAGE_BITS]),
    .lk_kind_o  (lk_kind),
    .lk_dev_o   (lk_dev),
    .lk_wide_o  (lk_wide),
    .lk_base_o  (lk_base)
  );

  mmio_xfer #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .NDEV(NDEV)) u_xfer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (acc_go),
    .we_i        (acc_we_i),
    .word_i      (acc_word_i),
    .addr_i      (acc_addr_i),
    .wdata_i     (acc_wdata_i),
    .kind_i      (lk_kind),
    .dev_i       (lk_dev),
    .wide_i      (lk_wide),
    .base_i      (lk_base),
    .idle_o      (xfer_idle),
    .done_o      (acc_done_o),
    .miss_o      (acc_miss_o),
    .rdata_o     (acc_rdata_o),
    .dev_req_o   (dev_req_o),
    .dev_sel_o   (dev_sel_o),
    .dev_we_o    (dev_we_o),
    .dev_wide_o  (dev_wide_o),
    .dev_off_o   (dev_off_o),
    .dev_wdata_o (dev_wdata_o),
    .dev_rdata_i (dev_rdata_i)
  );

  AST_REG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_busy_o |-> !dev_req_o && !acc_ready_o); // R3
  AST_MISS_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_miss_o |-> !$past(dev_req_o)); // R10
endmodule

// File: tb/tb_mmio_dispatch.sv
`timescale 1ns/1ps
module tb_mmio_dispatch;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        reg_valid = 0, reg_wide = 0;
  logic [31:0] reg_base = 0, reg_size = 0;
  logic [2:0]  reg_dev = 0;
  logic        reg_busy, reg_err;
  logic        acc_valid = 0, acc_we = 0, acc_word = 0;
  logic [31:0] acc_addr = 0, acc_wdata = 0;
  logic        acc_ready, acc_done, acc_miss;
  logic [31:0] acc_rdata;
  logic        dev_req, dev_we, dev_wide;
  logic [2:0]  dev_sel;
  logic [31:0] dev_off, dev_wdata, dev_rdata;

  int checks = 0, failures = 0;
  bit fin = 0;

  function automatic logic [31:0] mdl(input logic [2:0] s, input logic [31:0] o);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[8*k +: 8] = (o[7:0] + 8'(k)) ^ {1'b0, s, 4'h0};
    return r;
  endfunction

  assign dev_rdata = mdl(dev_sel, dev_off);

  mmio_dispatch dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_valid_i(reg_valid), .reg_base_i(reg_base), .reg_size_i(reg_size),
    .reg_dev_i(reg_dev), .reg_wide_i(reg_wide), .reg_busy_o(reg_busy), .reg_err_o(reg_err),
    .acc_valid_i(acc_valid), .acc_ready_o(acc_ready), .acc_we_i(acc_we), .acc_word_i(acc_word),
    .acc_addr_i(acc_addr), .acc_wdata_i(acc_wdata), .acc_done_o(acc_done), .acc_miss_o(acc_miss),
    .acc_rdata_o(acc_rdata), .dev_req_o(dev_req), .dev_sel_o(dev_sel), .dev_we_o(dev_we),
    .dev_wide_o(dev_wide), .dev_off_o(dev_off), .dev_wdata_o(dev_wdata), .dev_rdata_i(dev_rdata)
  );

  int          nreq = 0;
  logic [2:0]  q_sel [8];
  logic [31:0] q_off [8];
  logic [31:0] q_wd  [8];
  logic        q_we  [8];
  logic        q_wide[8];

  always @(negedge clk) if (dev_req && nreq < 8) begin
    q_sel[nreq] <= dev_sel; q_off[nreq] <= dev_off; q_wd[nreq] <= dev_wdata;
    q_we[nreq] <= dev_we; q_wide[nreq] <= dev_wide;
    nreq <= nreq + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [31:0] rd;
  logic        ms;
  int          cyc;

  task automatic acc(input logic we, input logic word, input logic [31:0] a, input logic [31:0] wd);
    @(negedge clk);
    while (!acc_ready) @(negedge clk);
    nreq = 0;
    acc_valid = 1; acc_we = we; acc_word = word; acc_addr = a; acc_wdata = wd;
    @(negedge clk);
    acc_valid = 0;
    cyc = 1;
    while (!acc_done && cyc < 50) begin @(negedge clk); cyc++; end
    rd = acc_rdata; ms = acc_miss;
  endtask

  logic er;
  int   bcyc;
  bit   leak;

  task automatic regn(input logic [31:0] b, input logic [31:0] s, input logic [2:0] d, input logic w);
    @(negedge clk);
    while (reg_busy) @(negedge clk);
    reg_valid = 1; reg_base = b; reg_size = s; reg_dev = d; reg_wide = w;
    @(negedge clk);
    reg_valid = 0;
    er = reg_err; bcyc = 0; leak = 0;
    while (reg_busy && bcyc < 100) begin
      if (acc_ready || dev_req) leak = 1;
      bcyc++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!reg_busy && !reg_err && !acc_done && !dev_req && acc_ready, "R11 reset outputs",
        {27'h0, reg_busy, reg_err, acc_done, dev_req, acc_ready}, 32'h1);
  endtask

  task automatic t_sink;
    acc(0, 1, 32'h000C_0000, 0);
    chk(rd == 32'hFFFF_FFFF && nreq == 0 && cyc == 1, "R1 sink word read", rd, 32'hFFFF_FFFF);
    acc(0, 0, 32'h8000_0123, 0);
    chk(rd == 32'h0000_00FF && nreq == 0, "R1 sink byte read above table", rd, 32'hFF);
    acc(1, 1, 32'h000C_0040, 32'h1234_5678);
    chk(nreq == 0 && cyc == 1, "R1 sink write dropped", nreq, 0);
    acc(0, 1, 32'h000C_0040, 0);
    chk(rd == 32'hFFFF_FFFF, "R1 sink read after write", rd, 32'hFFFF_FFFF);
  endtask

  task automatic t_miss;
    acc(0, 1, 32'h0001_0000, 0);
    chk(ms && rd == 0 && nreq == 0 && cyc == 1, "R10 unclaimed RAM page", {ms, rd[30:0]}, 32'h8000_0000);
  endtask

  task automatic t_errors;
    regn(32'h0008_1000, 32'h4000, 3'd1, 0);
    chk(er && bcyc == 0, "R2 misaligned base", {er, 31'(bcyc)}, 32'h8000_0000);
    regn(32'h0008_0000, 32'h1000, 3'd1, 0);
    chk(er && bcyc == 0, "R2 misaligned size", {er, 31'(bcyc)}, 32'h8000_0000);
    regn(32'h0008_0000, 32'h0, 3'd1, 0);
    chk(er && bcyc == 0, "R2 zero size", {er, 31'(bcyc)}, 32'h8000_0000);
    regn(32'h000F_C000, 32'h8000, 3'd1, 0);
    chk(er && bcyc == 0, "R2 beyond table", {er, 31'(bcyc)}, 32'h8000_0000);
    acc(0, 1, 32'h000F_C000, 0);
    chk(rd == 32'hFFFF_FFFF && nreq == 0, "R2 table unchanged", rd, 32'hFFFF_FFFF);
  endtask

  task automatic t_byte_region;
    logic [31:0] e;
    regn(32'h000A_0000, 32'h8000, 3'd3, 0);
    chk(!er && bcyc == 2 && !leak, "R3 busy two pages", 32'(bcyc), 2);
    acc(0, 1, 32'h000A_4010, 0);
    e = mdl(3'd3, 32'h4010);
    chk(rd == e && cyc == 5, "R7 split read little-endian", rd, e);
    chk(nreq == 4 && q_off[0] == 32'h4010 && q_off[3] == 32'h4013 && !q_wide[0],
        "R7 four byte requests", q_off[3], 32'h4013);
    chk(q_sel[0] == 3'd3 && q_sel[3] == 3'd3, "R5 select index", 32'(q_sel[0]), 3);
    acc(1, 1, 32'h000A_0004, 32'hDEAD_BEEF);
    chk(nreq == 4 && q_we[0] && q_wd[0][7:0] == 8'hEF && q_wd[1][7:0] == 8'hBE &&
        q_wd[2][7:0] == 8'hAD && q_wd[3][7:0] == 8'hDE,
        "R8 split write byte order", {q_wd[3][7:0], q_wd[2][7:0], q_wd[1][7:0], q_wd[0][7:0]}, 32'hDEAD_BEEF);
    chk(q_off[0] == 32'h4, "R5 region offset", q_off[0], 32'h4);
    acc(0, 0, 32'h000A_0007, 0);
    e = {24'h0, mdl(3'd3, 32'h7)[7:0]};
    chk(rd == e && nreq == 1 && !q_wide[0] && cyc == 2, "R9 byte read", rd, e);
  endtask

  task automatic t_wide_region;
    logic [31:0] e;
    regn(32'h000C_0000, 32'h4000, 3'd6, 1);
    chk(!er && bcyc == 1 && !leak, "R3 busy one page", 32'(bcyc), 1);
    acc(0, 1, 32'h000C_0100, 0);
    e = mdl(3'd6, 32'h100);
    chk(rd == e && nreq == 1 && q_wide[0] && cyc == 2, "R6 wide read single", rd, e);
    acc(1, 1, 32'h000C_0200, 32'hCAFE_F00D);
    chk(nreq == 1 && q_wd[0] == 32'hCAFE_F00D && q_off[0] == 32'h200, "R6 wide write", q_wd[0], 32'hCAFE_F00D);
    acc(0, 0, 32'h000C_0103, 0);
    e = {24'h0, mdl(3'd6, 32'h103)[7:0]};
    chk(rd == e && nreq == 1 && !q_wide[0], "R9 byte read in wide region", rd, e);
  endtask

  task automatic t_overwrite;
    regn(32'h000A_4000, 32'h4000, 3'd2, 0);
    acc(0, 0, 32'h000A_4000, 0);
    chk(nreq == 1 && q_sel[0] == 3'd2 && q_off[0] == 0, "R4 overlap rebound", 32'(q_sel[0]), 2);
    acc(0, 0, 32'h000A_0000, 0);
    chk(nreq == 1 && q_sel[0] == 3'd3 && q_off[0] == 0, "R4 old page kept", 32'(q_sel[0]), 3);
  endtask

  task automatic t_low_region;
    regn(32'h0000_8000, 32'h4000, 3'd1, 1);
    acc(0, 1, 32'h0000_8020, 0);
    chk(!ms && nreq == 1 && q_sel[0] == 3'd1 && q_off[0] == 32'h20, "R5 region below RAM", q_off[0], 32'h20);
    acc(0, 1, 32'h0000_C000, 0);
    chk(ms && nreq == 0, "R10 neighbour still unclaimed", {31'h0, ms}, 1);
  endtask

  initial begin
    #(4 * 100000);
    if (!fin) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_sink();
    t_miss();
    t_errors();
    t_byte_region();
    t_wide_region();
    t_overwrite();
    t_low_region();
    fin = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule